// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a keypad wired as six drive lines crossed with five sense inputs, giving up to 30 keys. While nothing is pressed it parks the drive lines at an idle pattern and waits. A sense input going high starts a scan: each drive line is raised alone for a fixed window of timebase ticks while the others stay low, and the sense inputs are sampled near the end of each window. Two back-to-back scans are compared. Only when they agree and at least one key is down is the pattern latched as the key data and an active-low request raised to the host. When they disagree the whole confirmation period is run again.

The host answers the request by reading the key data through the serial block, which then pulses a read-done input. That pulse drops the request and starts a fresh scan, so a key that is still held produces a new request one confirmation period later. Once a confirmed scan finds every key released, the block returns to idle. A sleep code selects reduced idle drive patterns so that only some lines can wake the part. While the block sleeps and has a scan to run, it raises a wake request for the oscillator. A line-select code hands the first one or two drive lines over to other use. Those lines are then never driven and their key bits stay 0.

Top module: `keyscan_matrix`

## Requirements
- R1: Key bit k of `key_data` is (line-1)*5 + (input-1), where line 1 is `drive[0]` and input 1 is `sense[0]`. Line 1 input 1 is bit 0 and line 6 input 5 is bit 29.
- R2: During the scan part of a cycle no more than one drive line is high. Line 1 comes first and each line is held for 48 ticks, so line 2 is high 48 to 95 ticks after the start and line 4 is high 144 to 191 ticks after it.
- R3: When both scans of a cycle agree and are nonzero, `req_n` goes low in the clock that takes the 615th tick after the scan started, and `key_data` then holds the confirmed pattern.
- R4: When the two scans of a cycle disagree the cycle restarts, so a held pattern that changed during the first cycle is reported after 1230 ticks.
- R5: A press released before the two scans agree is never reported. `req_n` stays high, `key_data` keeps its previous value, and the block returns to idle.
- R6: In idle with sleep code 00, every enabled drive line is high. A scan starts only in the clock after a sense input is high, and without one the block stays idle.
- R7: A `read_done` pulse while the request is pending raises `req_n` in the next clock and starts a new scan at line 1. A key still held is reported again 615 ticks later. The request does not drop without a `read_done` pulse.
- R8: The idle drive pattern follows `sleep_code`. 00 drives all lines high, 01 drives only line 6 high, 10 drives lines 5 and 6 high, and 11 drives lines 2 to 6 high.
- R9: With a nonzero sleep code, a key on an idle-low line starts nothing. A key on an idle-high line starts a scan, and `wake_req` is high for the whole scan. After the read, the sleep idle pattern returns.
- R10: `line_sel` 00 enables all six lines. 01 disables line 1. 10 and 11 disable lines 1 and 2. A disabled line is never driven, and its key bits read 0.
- R11: While `rst` is high (synchronous, active high) scanning stops, `key_data` clears to 0, `req_n` is high and the drive lines show the idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase enable, one clock wide per tick T |
| sense | input | 5 | Synchronized sense inputs, bit 0 is input 1 |
| sleep_code | input | 2 | Sleep code, 00 is normal mode |
| line_sel | input | 2 | Drive-line enable code |
| read_done | input | 1 | One-clock pulse after the host has read the key data |
| drive | output | 6 | Drive lines, bit 0 is line 1 |
| key_data | output | 30 | Confirmed key pattern |
| req_n | output | 1 | Read request, active low |
| wake_req | output | 1 | Oscillator wake request in sleep mode |

## Verification
The bench times the request to the exact tick count. A sequencer that compares one window too early or too late reports at 614 or 616 instead of 615. A key added between the two sampling passes must push the report to 1230 ticks, so a design that latches without comparing shows up at once. A short press on the last line, released between that line's two samples, must vanish without a request, which catches a design that reports the first nonzero scan. The sleep tests press a key on an idle-low line that must be ignored and then one on an idle-high line that must wake the block. The line-select tests press keys on disabled lines, so a design that forgets the mask shows stray bits in the key data.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    localparam int KS_LINES   = 6;
    localparam int KS_INPUTS  = 5;
    localparam int KS_KEYS    = KS_LINES * KS_INPUTS;
    localparam int KS_LINE_W  = $clog2(KS_LINES);

    typedef logic [KS_LINES-1:0] line_vec_t;
    typedef logic [KS_KEYS-1:0]  key_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } ks_state_e;

    // Lines usable for scanning under the line-select code.
    function automatic line_vec_t line_enable(input logic [1:0] sel);
        line_vec_t m;
        m = '1;
        if (sel[1])      m[1:0] = 2'b00;
        else if (sel[0]) m[0]   = 1'b0;
        return m;
    endfunction

    // Idle drive pattern selected by the sleep code.
    function automatic line_vec_t idle_pattern(input logic [1:0] code);
        line_vec_t m;
        case (code)
            2'b00:   m = '1;
            2'b01:   m = line_vec_t'(1) << (KS_LINES - 1);
            2'b10:   m = line_vec_t'(3) << (KS_LINES - 2);
            default: begin m = '1; m[0] = 1'b0; end
        endcase
        return m;
    endfunction

    // Expand a per-line enable into a per-key enable.
    function automatic key_vec_t key_mask(input line_vec_t en);
        key_vec_t m;
        for (int l = 0; l < KS_LINES; l++)
            for (int s = 0; s < KS_INPUTS; s++)
                m[l*KS_INPUTS + s] = en[l];
        return m;
    endfunction

endpackage

// File: rtl/ks_seq.sv
module ks_seq
    import keyscan_pkg::*;
#(
    parameter int WIN_T      = 48,
    parameter int CONF_T     = 615,
    parameter int SAMPLE_OFS = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 any_sense,
    input  logic                 read_done,
    input  logic                 match,
    input  logic                 nonzero,
    output ks_state_e            state,
    output logic                 scanning,
    output logic [KS_LINE_W-1:0] line_idx,
    output logic                 pass,
    output logic                 sample_en,
    output logic                 scan_start,
    output logic                 load_key
);
    localparam int SCAN_T = WIN_T * KS_LINES;
    localparam int CYC_W  = $clog2(CONF_T + 1);
    localparam int SUB_W  = $clog2(WIN_T);

    ks_state_e            state_q, state_d;
    logic [CYC_W-1:0]     cyc_q;
    logic [SUB_W-1:0]     sub_q;
    logic [KS_LINE_W-1:0] line_q;
    logic                 pass_q;
    logic                 eval;

    assign state     = state_q;
    assign line_idx  = line_q;
    assign pass      = pass_q;
    assign scanning  = (state_q == ST_SCAN) && (cyc_q < CYC_W'(2 * SCAN_T));
    assign sample_en = scanning && tick && (sub_q == SUB_W'(WIN_T - 1 - SAMPLE_OFS));
    assign eval      = (state_q == ST_SCAN) && tick && (cyc_q == CYC_W'(CONF_T - 1));

    always_comb begin
        state_d    = state_q;
        scan_start = 1'b0;
        load_key   = 1'b0;
        case (state_q)
            ST_IDLE: if (any_sense) begin
                state_d    = ST_SCAN;
                scan_start = 1'b1;
            end
            ST_SCAN: if (eval) begin
                if (!match) begin
                    scan_start = 1'b1;
                end else if (nonzero) begin
                    state_d  = ST_HOLD;
                    load_key = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_HOLD: if (read_done) begin
                state_d    = ST_SCAN;
                scan_start = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            sub_q   <= '0;
            line_q  <= '0;
            pass_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (scan_start) begin
                cyc_q  <= '0;
                sub_q  <= '0;
                line_q <= '0;
                pass_q <= 1'b0;
            end else if ((state_q == ST_SCAN) && tick) begin
                cyc_q <= cyc_q + 1'b1;
                if (scanning) begin
                    if (sub_q == SUB_W'(WIN_T - 1)) begin
                        sub_q <= '0;
                        if (line_q == KS_LINE_W'(KS_LINES - 1)) begin
                            line_q <= '0;
                            pass_q <= ~pass_q;
                        end else begin
                            line_q <= line_q + 1'b1;
                        end
                    end else begin
                        sub_q <= sub_q + 1'b1;
                    end
                end
            end
        end
    end

    // R3: the hold state is only entered at the end of a full confirmation period
    p_req_after_confirm_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && $past(state_q) != ST_HOLD) |-> $past(cyc_q) == CYC_W'(CONF_T - 1));

    // R7: a read restarts scanning from the first window
    p_read_resume_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD && read_done) |=> (state_q == ST_SCAN && cyc_q == '0 && line_q == '0));

    // R6: without a sense input the idle state is kept
    p_idle_stay_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !any_sense) |=> state_q == ST_IDLE);

endmodule

// File: rtl/ks_capture.sv
module ks_capture
    import keyscan_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_en,
    input  logic                 scan_start,
    input  logic                 load_key,
    input  logic                 pass,
    input  logic [KS_LINE_W-1:0] line_idx,
    input  line_vec_t            line_en,
    input  logic [KS_INPUTS-1:0] sense,
    output logic                 match,
    output logic                 nonzero,
    output key_vec_t             key_data
);
    key_vec_t first_q, second_q, key_q;

    assign match    = (first_q == second_q);
    assign nonzero  = |first_q;
    assign key_data = key_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q  <= '0;
            second_q <= '0;
            key_q    <= '0;
        end else begin
            if (scan_start) begin
                first_q  <= '0;
                second_q <= '0;
            end else if (sample_en) begin
                for (int l = 0; l < KS_LINES; l++) begin
                    if (line_idx == KS_LINE_W'(l)) begin
                        for (int s = 0; s < KS_INPUTS; s++) begin
                            if (!pass) first_q[l*KS_INPUTS + s]  <= sense[s] & line_en[l];
                            else       second_q[l*KS_INPUTS + s] <= sense[s] & line_en[l];
                        end
                    end
                end
            end
            if (load_key) key_q <= first_q;
        end
    end

    // R10: a freshly confirmed pattern carries no bit of a disabled line
    p_keys_masked_r10: assert property (@(posedge clk) disable iff (rst)
        load_key |=> ((key_q & ~key_mask($past(line_en))) == '0));

endmodule

// File: rtl/ks_drive.sv
module ks_drive
    import keyscan_pkg::*;
(
    input  ks_state_e            state,
    input  logic                 scanning,
    input  logic [KS_LINE_W-1:0] line_idx,
    input  logic [1:0]           sleep_code,
    input  logic [1:0]           line_sel,
    output line_vec_t            drive,
    output line_vec_t            line_en
);
    line_vec_t idle;

    assign line_en = line_enable(line_sel);
    assign idle    = idle_pattern(sleep_code);

    for (genvar i = 0; i < KS_LINES; i++) begin : g_line
        assign drive[i] = line_en[i] &
            (scanning ? (line_idx == KS_LINE_W'(i))
                      : ((state != ST_SCAN) & idle[i]));
    end

endmodule

// File: rtl/keyscan_matrix.sv
module keyscan_matrix
    import keyscan_pkg::*;
#(
    parameter int WIN_T      = 48,
    parameter int CONF_T     = 615,
    parameter int SAMPLE_OFS = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [KS_INPUTS-1:0] sense,
    input  logic [1:0]           sleep_code,
    input  logic [1:0]           line_sel,
    input  logic                 read_done,
    output logic [KS_LINES-1:0]  drive,
    output logic [KS_KEYS-1:0]   key_data,
    output logic                 req_n,
    output logic                 wake_req
);
    ks_state_e            state;
    logic                 scanning, pass, sample_en, scan_start, load_key;
    logic                 match, nonzero, any_sense;
    logic [KS_LINE_W-1:0] line_idx;
    line_vec_t            line_en;

    assign any_sense = |sense;
    assign req_n     = (state != ST_HOLD);
    assign wake_req  = (|sleep_code) &
                       ((state == ST_SCAN) | ((state == ST_IDLE) & any_sense));

    ks_seq #(
        .WIN_T      (WIN_T),
        .CONF_T     (CONF_T),
        .SAMPLE_OFS (SAMPLE_OFS)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .any_sense  (any_sense),
        .read_done  (read_done),
        .match      (match),
        .nonzero    (nonzero),
        .state      (state),
        .scanning   (scanning),
        .line_idx   (line_idx),
        .pass       (pass),
        .sample_en  (sample_en),
        .scan_start (scan_start),
        .load_key   (load_key)
    );

    ks_capture cap_i (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .scan_start (scan_start),
        .load_key   (load_key),
        .pass       (pass),
        .line_idx   (line_idx),
        .line_en    (line_en),
        .sense      (sense),
        .match      (match),
        .nonzero    (nonzero),
        .key_data   (key_data)
    );

    ks_drive drv_i (
        .state      (state),
        .scanning   (scanning),
        .line_idx   (line_idx),
        .sleep_code (sleep_code),
        .line_sel   (line_sel),
        .drive      (drive),
        .line_en    (line_en)
    );

    // R2: at most one drive line is high while a scan pass runs
    p_one_line_r2: assert property (@(posedge clk) disable iff (rst)
        scanning |-> $onehot0(drive));

    // R9: a sleeping block keeps the oscillator requested during a scan
    p_wake_on_scan_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SCAN && sleep_code != 2'b00) |-> wake_req);

    // R7: a pending request only drops on a read
    p_req_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (!req_n && !read_done) |=> !req_n);

    // R11: reset clears key data and the request
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (req_n && key_data == '0));

endmodule

// File: tb/keyscan_matrix_tb_top.sv
module keyscan_matrix_tb_top;

    typedef struct packed {
        logic [1:0]  sel;
        logic [1:0]  code;
        logic [29:0] keys;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{sel: 2'b00, code: 2'b00, keys: 30'h0000_0001},
        '{sel: 2'b00, code: 2'b00, keys: 30'h2000_0000},
        '{sel: 2'b00, code: 2'b00, keys: 30'h0000_2080},
        '{sel: 2'b01, code: 2'b00, keys: 30'h0000_0401},
        '{sel: 2'b10, code: 2'b00, keys: 30'h0000_8021},
        '{sel: 2'b00, code: 2'b11, keys: 30'h0000_0040},
        '{sel: 2'b11, code: 2'b10, keys: 30'h0100_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        read_done = 1'b0;
    logic [1:0]  sleep_code = 2'b00;
    logic [1:0]  line_sel = 2'b00;
    logic [29:0] pressed = '0;
    logic [4:0]  sense;
    logic [5:0]  drive;
    logic [29:0] key_data;
    logic        req_n, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    int tick_total = 0;
    int tdiv = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // key matrix model: a pressed key connects its drive line to its sense input
    always_comb begin
        sense = '0;
        for (int l = 0; l < 6; l++)
            for (int s = 0; s < 5; s++)
                if (drive[l] && pressed[l*5 + s]) sense[s] = 1'b1;
    end

    always @(negedge clk) begin
        tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
        tick <= (tdiv == 2);
    end

    always @(posedge clk) if (tick) tick_total <= tick_total + 1;

    keyscan_matrix dut_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .sense      (sense),
        .sleep_code (sleep_code),
        .line_sel   (line_sel),
        .read_done  (read_done),
        .drive      (drive),
        .key_data   (key_data),
        .req_n      (req_n),
        .wake_req   (wake_req)
    );

    function automatic logic [5:0] en_lines(input logic [1:0] sel);
        if (sel == 2'b00) return 6'h3F;
        if (sel == 2'b01) return 6'h3E;
        return 6'h3C;
    endfunction

    function automatic logic [5:0] idle_exp(input logic [1:0] code, input logic [1:0] sel);
        logic [5:0] p;
        case (code)
            2'b00: p = 6'h3F;
            2'b01: p = 6'h20;
            2'b10: p = 6'h30;
            default: p = 6'h3E;
        endcase
        return p & en_lines(sel);
    endfunction

    function automatic logic [29:0] keys_exp(input logic [29:0] k, input logic [1:0] sel);
        logic [29:0] r;
        logic [5:0]  en;
        en = en_lines(sel);
        r = '0;
        for (int l = 0; l < 6; l++)
            for (int s = 0; s < 5; s++)
                r[l*5 + s] = k[l*5 + s] & en[l];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int base;
        base = tick_total;
        while (tick_total - base < n) @(negedge clk);
    endtask

    task automatic wait_req(input int base, input int limit, output int seen);
        while (req_n && (tick_total - base < limit)) @(negedge clk);
        seen = req_n ? -1 : tick_total - base;
    endtask

    task automatic pulse_read();
        read_done = 1'b1;
        @(negedge clk);
        read_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    initial begin
        int base, seen;
        logic [29:0] prev;

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(req_n == 1'b1, "R11 req_n in reset", req_n, 1);
        chk(key_data == '0, "R11 key_data in reset", key_data, 0);
        chk(drive == 6'h3F, "R11 drive idle in reset", drive, 6'h3F);
        rst = 1'b0;
        @(negedge clk);

        // R6: no key, stay idle
        wait_ticks(200);
        chk(req_n == 1'b1, "R6 no request without key", req_n, 1);
        chk(drive == 6'h3F, "R6 idle drive all high", drive, 6'h3F);

        // vector table: R1 R3 R8 R10 over modes
        for (int v = 0; v < NV; v++) begin
            line_sel   = VECS[v].sel;
            sleep_code = VECS[v].code;
            pressed    = '0;
            repeat (2) @(negedge clk);
            chk(drive == idle_exp(VECS[v].code, VECS[v].sel), "R8 idle pattern",
                drive, idle_exp(VECS[v].code, VECS[v].sel));
            pressed = VECS[v].keys;
            @(negedge clk);
            base = tick_total;
            wait_req(base, 700, seen);
            chk(seen == 615, "R3 request tick count", seen, 615);
            chk(key_data == keys_exp(VECS[v].keys, VECS[v].sel), "R1 R10 key data",
                key_data, keys_exp(VECS[v].keys, VECS[v].sel));
            pressed = '0;
            pulse_read();
            chk(req_n == 1'b1, "R7 request cleared by read", req_n, 1);
            wait_ticks(640);
            chk(drive == idle_exp(VECS[v].code, VECS[v].sel), "R6 back to idle",
                drive, idle_exp(VECS[v].code, VECS[v].sel));
        end

        // R11: reset in the middle of a scan
        line_sel = 2'b00; sleep_code = 2'b00;
        pressed = 30'h1;
        @(negedge clk);
        wait_ticks(100);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(key_data == '0, "R11 key cleared by reset", key_data, 0);
        chk(req_n == 1'b1, "R11 req high in reset", req_n, 1);
        chk(drive == 6'h3F, "R11 scan stopped in reset", drive, 6'h3F);
        pressed = '0;
        rst = 1'b0;
        wait_ticks(20);

        // R2: line walk, then R7 repeat report while held
        pressed = 30'h1;
        @(negedge clk);
        base = tick_total;
        chk(drive == 6'h01, "R2 line 1 first", drive, 6'h01);
        wait_ticks(50);
        chk(drive == 6'h02, "R2 line 2 window", drive, 6'h02);
        wait_ticks(100);
        chk(drive == 6'h08, "R2 line 4 window", drive, 6'h08);
        wait_req(base, 700, seen);
        chk(seen == 615, "R3 first report", seen, 615);
        wait_ticks(30);
        chk(req_n == 1'b0, "R7 request held until read", req_n, 0);
        pulse_read();
        chk(req_n == 1'b1, "R7 request dropped", req_n, 1);
        chk(drive == 6'h01, "R7 new scan at line 1", drive, 6'h01);
        base = tick_total;
        wait_req(base, 700, seen);
        chk(seen == 615, "R7 held key reported again", seen, 615);
        pressed = '0;
        pulse_read();
        wait_ticks(640);

        // R4: pattern changes between passes
        pressed = 30'h20;
        @(negedge clk);
        base = tick_total;
        wait_ticks(100);
        pressed = 30'h21;
        wait_req(base, 1400, seen);
        chk(seen == 1230, "R4 mismatch delays report", seen, 1230);
        chk(key_data == 30'h21, "R4 key data after repeat", key_data, 30'h21);
        pressed = '0;
        pulse_read();
        wait_ticks(640);

        // R5: short press never reported
        prev = key_data;
        pressed = 30'h0200_0000;
        @(negedge clk);
        base = tick_total;
        wait_ticks(300);
        pressed = '0;
        wait_req(base, 1300, seen);
        chk(seen == -1, "R5 short press ignored", seen, -1);
        chk(key_data == prev, "R5 key data unchanged", key_data, prev);
        chk(drive == 6'h3F, "R5 back to idle", drive, 6'h3F);

        // R9: sleep with only line 6 idle high
        sleep_code = 2'b01;
        @(negedge clk);
        chk(drive == 6'h20, "R8 code 01 pattern", drive, 6'h20);
        pressed = 30'h20;
        wait_ticks(200);
        chk(wake_req == 1'b0, "R9 idle-low line no wake", wake_req, 0);
        chk(req_n == 1'b1, "R9 idle-low line no report", req_n, 1);
        pressed = 30'h0200_0000;
        @(negedge clk);
        base = tick_total;
        chk(wake_req == 1'b1, "R9 wake on idle-high line", wake_req, 1);
        wait_ticks(300);
        chk(wake_req == 1'b1, "R9 wake held during scan", wake_req, 1);
        wait_req(base, 700, seen);
        chk(seen == 615, "R9 report in sleep", seen, 615);
        chk(key_data == 30'h0200_0000, "R9 key data in sleep", key_data, 30'h0200_0000);
        pressed = '0;
        pulse_read();
        wait_ticks(640);
        chk(drive == 6'h20, "R9 sleep pattern kept after read", drive, 6'h20);
        chk(wake_req == 1'b0, "R9 wake dropped in idle", wake_req, 0);

        finish_run();
    end

endmodule